// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block keeps an 8-bit status byte built from the summary flags of several status groups and a message-available flag from the output queue. It also holds an 8-bit service-request enable mask. From the two it forms a master-summary flag, and from the rising edge of that flag it forms a latched request-service flag. The request-service flag drives the service-request line.

The status byte is read in two ways, and both read values are always present on their own output buses. The poll byte carries the request-service flag in bit 6. A one-cycle poll strobe clears that flag and leaves the status byte as it is. The query byte carries the master-summary flag in bit 6.

A clear-status strobe empties the status byte except the message-available bit, and it also drops the request-service flag. The enable mask is not touched by the clear. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `srq_status_unit`

## Requirements
- R1: While reset is low, and after it is released with all inputs at zero, the poll byte, query byte, enable read-back, mss_o and srq_o are all zero.
- R2: Status byte bits 0–3, 5 and 7 take the value of the matching `summary_i` bits one clock edge after they are sampled. Bits 4 and 6 of `summary_i` have no effect on either read byte.
- R3: Status byte bit 4 equals `msg_avail_i` as sampled at the previous edge.
- R4: An enable write stores `enable_wdata_i` with bit 6 forced to 0. `enable_rdata_o` returns the stored mask, so its value always lies in 0–63 or 128–191.
- R5: `mss_o` is the OR over bits 0–5 and 7 of (status byte AND enable mask). Bit 6 of the query byte equals `mss_o`, and its other bits equal the status byte.
- R6: When `mss_o` changes from 0 to 1, `srq_o` becomes 1 at the next edge. Bit 6 of the poll byte equals `srq_o`.
- R7: A poll strobe clears `srq_o` at the next edge. The status byte bits in the poll and query bytes are unchanged by the poll.
- R8: If a poll strobe falls in the same cycle in which a new 0-to-1 change of `mss_o` is being registered, the new request wins and `srq_o` is 1 after the edge.
- R9: A clear-status strobe zeroes every status byte bit except bit 4, which keeps following `msg_avail_i`. It also clears `srq_o`, and it leaves the enable mask unchanged.
- R10: While `mss_o` stays at 1, a cleared `srq_o` stays at 0. Only a new 0-to-1 change raises it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| summary_i | input | 8 | Summary flags from the status groups (bits 4 and 6 unused) |
| msg_avail_i | input | 1 | Output queue holds a message |
| enable_we_i | input | 1 | Write strobe for the enable mask |
| enable_wdata_i | input | 8 | Enable mask write value |
| enable_rdata_o | output | 8 | Stored enable mask (bit 6 always 0) |
| poll_i | input | 1 | Serial-poll strobe, clears the request flag |
| poll_byte_o | output | 8 | Status byte with the request flag in bit 6 |
| query_byte_o | output | 8 | Status byte with the master-summary flag in bit 6 |
| clear_i | input | 1 | Clear-status strobe |
| mss_o | output | 1 | Master-summary flag |
| srq_o | output | 1 | Service-request line |

## Verification
The bench writes masks with bit 6 set and drives summary bit 6 high, to catch a design that leaks that bit into the enable mask or the status byte. It polls while the master summary stays high, to catch a design that re-raises the request from the level instead of the edge. It also polls in the same cycle as a fresh rise, to catch a design that loses that new request. Clear-status is applied while a message is pending, which exposes a design that wipes the message-available bit, keeps the request or disturbs the enable mask.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int STB_W   = 8;
  parameter int RQS_POS = 6;
  parameter int MAV_POS = 4;

  typedef logic [STB_W-1:0] stb_t;

  localparam stb_t RQS_MASK = stb_t'(1) << RQS_POS;
  localparam stb_t MAV_MASK = stb_t'(1) << MAV_POS;
  localparam stb_t SRC_MASK = ~(RQS_MASK | MAV_MASK);
endpackage

// File: rtl/sb_capture.sv
module sb_capture
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  stb_t summary_i,
  input  logic mav_i,
  input  logic clear_i,
  output stb_t stb_o
);
  stb_t stb_q, stb_d;

  always_comb begin
    stb_d          = clear_i ? '0 : (summary_i & SRC_MASK);
    stb_d[MAV_POS] = mav_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  assign stb_o = stb_q;

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((stb_o & SRC_MASK) == ($past(summary_i) & SRC_MASK)));

  p_mav_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stb_o[MAV_POS] == $past(mav_i)));

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ((stb_o & ~MAV_MASK) == '0));
endmodule

// File: rtl/sb_enable.sv
module sb_enable
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  stb_t wdata_i,
  output stb_t mask_o
);
  stb_t mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & ~RQS_MASK;
  end

  assign mask_o = mask_q;

  p_write_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == ($past(wdata_i) & ~RQS_MASK)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/sb_request.sv
module sb_request
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  stb_t stb_i,
  input  stb_t mask_i,
  input  logic poll_i,
  input  logic clear_i,
  output logic mss_o,
  output logic rqs_o
);
  logic mss_prev_q, rqs_q, rise;

  assign mss_o = |(stb_i & mask_i & ~RQS_MASK);
  assign rise  = mss_o & ~mss_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mss_prev_q <= 1'b0;
      rqs_q      <= 1'b0;
    end else begin
      mss_prev_q <= mss_o;
      if (clear_i)     rqs_q <= 1'b0;
      else if (rise)   rqs_q <= 1'b1;
      else if (poll_i) rqs_q <= 1'b0;
    end
  end

  assign rqs_o = rqs_q;

  p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mss_o && !mss_prev_q && !clear_i) |=> rqs_o);

  p_poll_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && !clear_i && !(mss_o && !mss_prev_q)) |=> !rqs_o);

  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !rqs_o);

  p_no_level_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rqs_o && !(mss_o && !mss_prev_q)) |=> !rqs_o);
endmodule

// File: rtl/srq_status_unit.sv
module srq_status_unit
  import sb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] summary_i,
  input  logic             msg_avail_i,
  input  logic             enable_we_i,
  input  logic [STB_W-1:0] enable_wdata_i,
  output logic [STB_W-1:0] enable_rdata_o,
  input  logic             poll_i,
  output logic [STB_W-1:0] poll_byte_o,
  output logic [STB_W-1:0] query_byte_o,
  input  logic             clear_i,
  output logic             mss_o,
  output logic             srq_o
);
  stb_t stb, mask;
  logic mss, rqs;

  sb_capture u_capture (
    .clk(clk), .rst_n(rst_n), .summary_i(summary_i), .mav_i(msg_avail_i),
    .clear_i(clear_i), .stb_o(stb)
  );

  sb_enable u_enable (
    .clk(clk), .rst_n(rst_n), .we_i(enable_we_i), .wdata_i(enable_wdata_i),
    .mask_o(mask)
  );

  sb_request u_request (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .mask_i(mask), .poll_i(poll_i),
    .clear_i(clear_i), .mss_o(mss), .rqs_o(rqs)
  );

  always_comb begin
    poll_byte_o           = stb;
    poll_byte_o[RQS_POS]  = rqs;
    query_byte_o          = stb;
    query_byte_o[RQS_POS] = mss;
  end

  assign enable_rdata_o = mask;
  assign mss_o          = mss;
  assign srq_o          = rqs;

  p_enable_bit6_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable_we_i |=> !enable_rdata_o[RQS_POS]);

  p_poll_keeps_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && !clear_i && $stable(summary_i) && $stable(msg_avail_i))
      |=> ((poll_byte_o & ~RQS_MASK) == $past(poll_byte_o & ~RQS_MASK)));
endmodule

// File: tb/test_srq_status_unit.sv
module test_srq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] summary_i = '0;
  logic       msg_avail_i = 1'b0;
  logic       enable_we_i = 1'b0;
  logic [7:0] enable_wdata_i = '0;
  logic [7:0] enable_rdata_o;
  logic       poll_i = 1'b0;
  logic [7:0] poll_byte_o;
  logic [7:0] query_byte_o;
  logic       clear_i = 1'b0;
  logic       mss_o;
  logic       srq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  srq_status_unit i_srq_status_unit (
    .clk(clk), .rst_n(rst_n), .summary_i(summary_i), .msg_avail_i(msg_avail_i),
    .enable_we_i(enable_we_i), .enable_wdata_i(enable_wdata_i),
    .enable_rdata_o(enable_rdata_o), .poll_i(poll_i), .poll_byte_o(poll_byte_o),
    .query_byte_o(query_byte_o), .clear_i(clear_i), .mss_o(mss_o), .srq_o(srq_o)
  );

  // {summary, msg_avail, enable write, expected query byte, expected enable read}
  localparam logic [32:0] VEC [0:6] = '{
    {8'h00, 1'b0, 8'h00, 8'h00, 8'h00},
    {8'h01, 1'b0, 8'h01, 8'h41, 8'h01},
    {8'h40, 1'b0, 8'hFF, 8'h00, 8'hBF},
    {8'h80, 1'b1, 8'h80, 8'hD0, 8'h80},
    {8'h2C, 1'b0, 8'h10, 8'h2C, 8'h10},
    {8'h00, 1'b1, 8'h10, 8'h50, 8'h10},
    {8'hFF, 1'b0, 8'h40, 8'hAF, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 poll", poll_byte_o, 8'h00);
    check("R1 query", query_byte_o, 8'h00);
    check("R1 enable", enable_rdata_o, 8'h00);
    check("R1 srq", {7'b0, srq_o}, 8'h00);
    rst_n = 1'b1;
    tick();
    check("R1 after release", {poll_byte_o[7:1], mss_o}, 8'h00);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < 7; i++) begin
      summary_i      = VEC[i][32:25];
      msg_avail_i    = VEC[i][24];
      enable_wdata_i = VEC[i][23:16];
      enable_we_i    = 1'b1;
      tick();
      enable_we_i = 1'b0;
      check("R2/R3/R5 query byte", query_byte_o, VEC[i][15:8]);
      check("R4 enable read", enable_rdata_o, VEC[i][7:0]);
    end

    // clean state: mask 01, no summary
    summary_i = '0; msg_avail_i = 1'b0;
    enable_wdata_i = 8'h01; enable_we_i = 1'b1;
    clear_i = 1'b1;
    tick();
    enable_we_i = 1'b0; clear_i = 1'b0;
    tick();
    check("R9 srq after clear", {7'b0, srq_o}, 8'h00);

    // R6 rising master summary
    summary_i = 8'h01;
    tick();
    check("R5 mss up", {7'b0, mss_o}, 8'h01);
    check("R6 srq one edge later", {7'b0, srq_o}, 8'h00);
    tick();
    check("R6 srq set", {7'b0, srq_o}, 8'h01);
    check("R6 poll byte", poll_byte_o, 8'h41);

    // R7 poll clears flag only
    poll_i = 1'b1;
    tick();
    poll_i = 1'b0;
    check("R7 srq cleared", {7'b0, srq_o}, 8'h00);
    check("R7 poll byte", poll_byte_o, 8'h01);
    check("R7 query byte", query_byte_o, 8'h41);
    tick(); tick();
    check("R10 no retrigger on level", {7'b0, srq_o}, 8'h00);

    // R9 clear-status with message pending
    summary_i = 8'h00;
    tick();
    summary_i = 8'h01; msg_avail_i = 1'b1;
    tick(); tick();
    check("R6 srq re-raised", {7'b0, srq_o}, 8'h01);
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
    check("R9 query byte", query_byte_o, 8'h10);
    check("R9 srq", {7'b0, srq_o}, 8'h00);
    check("R9 enable kept", enable_rdata_o, 8'h01);

    // R8 poll during a fresh rise
    summary_i = 8'h00; msg_avail_i = 1'b0;
    tick(); tick();
    summary_i = 8'h01;
    tick();
    poll_i = 1'b1;
    tick();
    poll_i = 1'b0;
    check("R8 new request wins", {7'b0, srq_o}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule